// File: doc/BRIEF.md
# Ethernet Pause Frame Request Controller

This block sits beside a MAC transmitter and decides when a flow-control pause frame has to go out and which 16-bit pause time it carries. It compares the receive FIFO fill level against a programmable near-full threshold, watches a FIFO-empty flag and a receive-descriptor-unavailable flag, and accepts software commands that force a stop frame (time 0xFFFF, XOFF) or a resume frame (time 0x0000, XON). A request is offered to the transmitter on a request/accept/done handshake. Only one request is outstanding at any time.

The block also keeps a sticky status bit that records received pause frames reported by the receive parser. It sets only while received-pause decoding is enabled, and it clears when software reads it. Control and status go through a small synchronous register port. Location 0 is the control word and location 1 is the status word. Read data is combinational from the addressed register.

Internally a transmit state machine has three states. ST_IDLE means nothing is offered. ST_OFFER means the request is raised and the block waits for accept. ST_WAIT_DONE means the frame was accepted and the block waits for completion. The transitions are:
- IDLE to OFFER (launch XOFF or launch XON)
- OFFER to WAIT_DONE (accept)
- WAIT_DONE to IDLE (done)

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset the request output is low, and both the control word (location 0) and the status word (location 1) read as zero.
- R2: The control field in bits 5:0 is a threshold in units of 32 bytes. The FIFO counts as near full when its level is at least field×32, and a field value of 0 disables this condition. Entering near full while the trigger gate is open posts a request with timer 0xFFFF. Every offered timer is either 0x0000 or 0xFFFF.
- R3: Staying near full posts no further request after the first one has been served.
- R4: A rising edge of the FIFO-empty flag posts one request with timer 0x0000, but only if a hardware XOFF was posted earlier and no XON has followed it. Without such an XOFF the edge posts nothing.
- R5: The trigger gate depends on bit 8 (combine mode), bit 6 (FIFO trigger enable) and bit 7 (descriptor trigger enable). When bit 8 is 1, the gate is open if either enable is set. When bit 8 is 0, both enables must be set. Hardware trigger edges that arrive while the gate is closed are discarded.
- R6: A rising edge of the descriptor-unavailable input while the gate is open posts a request with timer 0xFFFF.
- R7: Writing 1 to control bit 9 posts one request with timer 0x0000. This bit always reads back as 0.
- R8: Writing 1 to control bit 10 posts a request with timer 0xFFFF. The bit reads back as 1 until the transmitter reports done for that 0xFFFF frame, and then it reads back as 0.
- R9: The request stays high with a stable timer until accept. It drops in the cycle after accept, and no new request is raised before done.
- R10: When an XOFF and an XON are pending together, the XOFF is offered first and the XON follows.
- R11: Status bit 0 sets when a received-pause event arrives while control bit 11 is 1. It ignores such events while bit 11 is 0, and it holds at 1 until read.
- R12: A read of location 1 returns the current status and clears it for the next cycle. A new event in the same cycle as the clearing read keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears status on location 1) |
| reg_addr | input | 1 | Register location: 0 control, 1 status |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data of the addressed register |
| fifo_level | input | 12 | Receive FIFO fill level in bytes |
| fifo_empty | input | 1 | Receive FIFO empty flag |
| desc_unavail | input | 1 | Receive descriptor unavailable flag |
| rx_pause_seen | input | 1 | One-cycle pulse: a pause frame was decoded on receive |
| tx_pause_req | output | 1 | Pause frame request to the transmitter |
| tx_pause_timer | output | 16 | Pause time carried by the requested frame |
| tx_pause_ack | input | 1 | Transmitter accepts the request |
| tx_pause_done | input | 1 | Transmitter finished sending the frame |

## Verification
A lost pending flag shows up at the ports as a request that never appears, which the bench catches within its short wait window after the trigger. A stuck edge register shows up as a repeated request, or a missing one, on the next level or flag change. A corrupted state or timer register changes the request or timer output in the very next cycle. The handshake assertions flag it at that edge. A wrong status or command bit is visible on the next read of the register port, and the checker also reports it in the cycle after the read or the done pulse.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int DATA_W    = 12;
    localparam int ADDR_W    = 1;
    localparam int TIMER_W   = 16;
    localparam int THR_W     = 6;
    localparam int THR_SHIFT = 5;
    localparam int THR_BITS  = THR_W + THR_SHIFT;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b1;

    // control word bit positions
    localparam int B_FIFO_EN = 6;
    localparam int B_DESC_EN = 7;
    localparam int B_ANYMODE = 8;
    localparam int B_CMD_XON = 9;
    localparam int B_CMD_XOF = 10;
    localparam int B_FC_EN   = 11;

    localparam logic [TIMER_W-1:0] TIMER_XOFF = '1;
    localparam logic [TIMER_W-1:0] TIMER_XON  = '0;

    typedef struct packed {
        logic [THR_W-1:0] thresh;
        logic             fifo_en;
        logic             desc_en;
        logic             any_mode;
        logic             fc_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_OFFER     = 2'd1,
        ST_WAIT_DONE = 2'd2
    } tx_state_e;

endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_pause_seen,
    input  logic              xoff_sent,
    output ctrl_t             ctrl,
    output logic              cmd_xoff,
    output logic              cmd_xon_pulse,
    output logic              status,
    output logic [DATA_W-1:0] rdata
);

    ctrl_t ctrl_q;
    logic  cmd_xoff_q;
    logic  status_q;
    logic  wr_ctrl;
    logic  rd_stat;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign rd_stat = rd_en && (addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.thresh   <= wdata[THR_W-1:0];
            ctrl_q.fifo_en  <= wdata[B_FIFO_EN];
            ctrl_q.desc_en  <= wdata[B_DESC_EN];
            ctrl_q.any_mode <= wdata[B_ANYMODE];
            ctrl_q.fc_en    <= wdata[B_FC_EN];
        end
    end

    // forced XOFF command: software sets, completion of an XOFF frame clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_xoff_q <= 1'b0;
        end else if (wr_ctrl) begin
            cmd_xoff_q <= wdata[B_CMD_XOF];
        end else if (xoff_sent) begin
            cmd_xoff_q <= 1'b0;
        end
    end

    // sticky receive status: a new event wins over the clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (rx_pause_seen && ctrl_q.fc_en) begin
            status_q <= 1'b1;
        end else if (rd_stat) begin
            status_q <= 1'b0;
        end
    end

    assign cmd_xon_pulse = wr_ctrl && wdata[B_CMD_XON];
    assign ctrl          = ctrl_q;
    assign cmd_xoff      = cmd_xoff_q;
    assign status        = status_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[THR_W-1:0] = ctrl_q.thresh;
            rdata[B_FIFO_EN] = ctrl_q.fifo_en;
            rdata[B_DESC_EN] = ctrl_q.desc_en;
            rdata[B_ANYMODE] = ctrl_q.any_mode;
            rdata[B_CMD_XON] = 1'b0;
            rdata[B_CMD_XOF] = cmd_xoff_q;
            rdata[B_FC_EN]   = ctrl_q.fc_en;
        end else begin
            rdata[0] = status_q;
        end
    end

endmodule

// File: rtl/pfc_trigger.sv
module pfc_trigger
    import pfc_pkg::*;
#(
    parameter int LEVEL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_empty,
    input  logic               desc_unavail,
    input  logic               sw_xon,
    input  logic               launch_xoff,
    input  logic               launch_xon,
    output logic               pend_xoff,
    output logic               pend_xon
);

    logic [THR_BITS-1:0] thr_bytes;
    logic                gate;
    logic                near_full;
    logic                near_q, empty_q, desc_q;
    logic                near_rise, empty_rise, desc_rise;
    logic                hw_xoff_evt, hw_xon_evt;
    logic                xoff_armed_q;
    logic                pend_xoff_q, pend_xon_q;

    assign thr_bytes = {ctrl.thresh, {THR_SHIFT{1'b0}}};
    assign near_full = (ctrl.thresh != '0) && (fifo_level >= LEVEL_W'(thr_bytes));
    assign gate      = ctrl.any_mode ? (ctrl.fifo_en || ctrl.desc_en)
                                     : (ctrl.fifo_en && ctrl.desc_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_q  <= 1'b0;
            empty_q <= 1'b0;
            desc_q  <= 1'b0;
        end else begin
            near_q  <= near_full;
            empty_q <= fifo_empty;
            desc_q  <= desc_unavail;
        end
    end

    assign near_rise   = near_full && !near_q;
    assign empty_rise  = fifo_empty && !empty_q;
    assign desc_rise   = desc_unavail && !desc_q;
    assign hw_xoff_evt = gate && (near_rise || desc_rise);
    assign hw_xon_evt  = gate && empty_rise && xoff_armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_armed_q <= 1'b0;
        end else if (hw_xoff_evt) begin
            xoff_armed_q <= 1'b1;
        end else if (hw_xon_evt) begin
            xoff_armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_xoff_q <= 1'b0;
        end else if (hw_xoff_evt) begin
            pend_xoff_q <= 1'b1;
        end else if (launch_xoff) begin
            pend_xoff_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_xon_q <= 1'b0;
        end else if (hw_xon_evt || sw_xon) begin
            pend_xon_q <= 1'b1;
        end else if (launch_xon) begin
            pend_xon_q <= 1'b0;
        end
    end

    assign pend_xoff = pend_xoff_q;
    assign pend_xon  = pend_xon_q;

endmodule

// File: rtl/pfc_tx_fsm.sv
module pfc_tx_fsm
    import pfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               want_xoff,
    input  logic               want_xon,
    input  logic               ack,
    input  logic               done,
    output logic               req,
    output logic [TIMER_W-1:0] timer,
    output logic               launch_xoff,
    output logic               launch_xon,
    output logic               xoff_sent
);

    tx_state_e          state_q, state_d;
    logic [TIMER_W-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (want_xoff || want_xon) state_d = ST_OFFER;
            ST_OFFER:     if (ack)                   state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (done)                  state_d = ST_IDLE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req         = 1'b0;
        launch_xoff = 1'b0;
        launch_xon  = 1'b0;
        xoff_sent   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch_xoff = want_xoff;
                launch_xon  = want_xon && !want_xoff;
            end
            ST_OFFER:     req       = 1'b1;
            ST_WAIT_DONE: xoff_sent = done && (timer_q == TIMER_XOFF);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= TIMER_XON;
        end else if (launch_xoff) begin
            timer_q <= TIMER_XOFF;
        end else if (launch_xon) begin
            timer_q <= TIMER_XON;
        end
    end

    assign timer = timer_q;

endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
    import pfc_pkg::*;
#(
    parameter int LEVEL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_empty,
    input  logic               desc_unavail,
    input  logic               rx_pause_seen,
    output logic               tx_pause_req,
    output logic [TIMER_W-1:0] tx_pause_timer,
    input  logic               tx_pause_ack,
    input  logic               tx_pause_done
);

    ctrl_t ctrl;
    logic  cmd_xoff, cmd_xon_pulse, status;
    logic  pend_xoff, pend_xon;
    logic  launch_xoff, launch_xon, xoff_sent;

    pfc_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr_en),
        .rd_en         (reg_rd_en),
        .addr          (reg_addr),
        .wdata         (reg_wdata),
        .rx_pause_seen (rx_pause_seen),
        .xoff_sent     (xoff_sent),
        .ctrl          (ctrl),
        .cmd_xoff      (cmd_xoff),
        .cmd_xon_pulse (cmd_xon_pulse),
        .status        (status),
        .rdata         (reg_rdata)
    );

    pfc_trigger #(.LEVEL_W(LEVEL_W)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .fifo_level   (fifo_level),
        .fifo_empty   (fifo_empty),
        .desc_unavail (desc_unavail),
        .sw_xon       (cmd_xon_pulse),
        .launch_xoff  (launch_xoff),
        .launch_xon   (launch_xon),
        .pend_xoff    (pend_xoff),
        .pend_xon     (pend_xon)
    );

    pfc_tx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_xoff   (pend_xoff || cmd_xoff),
        .want_xon    (pend_xon),
        .ack         (tx_pause_ack),
        .done        (tx_pause_done),
        .req         (tx_pause_req),
        .timer       (tx_pause_timer),
        .launch_xoff (launch_xoff),
        .launch_xon  (launch_xon),
        .xoff_sent   (xoff_sent)
    );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
    import pfc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               rx_pause_seen,
    input logic               fc_en,
    input logic               status,
    input logic               cmd_xoff,
    input logic               tx_pause_req,
    input logic [TIMER_W-1:0] tx_pause_timer,
    input logic               tx_pause_ack,
    input logic               tx_pause_done
);

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pause_req && !tx_pause_ack) |=> (tx_pause_req && $stable(tx_pause_timer)));

    assert_drop_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pause_req && tx_pause_ack) |=> !tx_pause_req);

    assert_timer_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause_req |-> (tx_pause_timer == TIMER_XON || tx_pause_timer == TIMER_XOFF));

    assert_xoff_cmd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pause_done && !tx_pause_req && tx_pause_timer == TIMER_XOFF && !reg_wr_en)
        |=> !cmd_xoff);

    assert_status_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == ADDR_STAT && !(rx_pause_seen && fc_en)) |=> !status);

    assert_status_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !(rx_pause_seen && fc_en)) |=> !status);

endmodule

bind pause_req_ctrl pfc_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_rd_en      (reg_rd_en),
    .reg_addr       (reg_addr),
    .rx_pause_seen  (rx_pause_seen),
    .fc_en          (ctrl.fc_en),
    .status         (status),
    .cmd_xoff       (cmd_xoff),
    .tx_pause_req   (tx_pause_req),
    .tx_pause_timer (tx_pause_timer),
    .tx_pause_ack   (tx_pause_ack),
    .tx_pause_done  (tx_pause_done)
);

// File: tb/pause_req_ctrl_tb.sv
module pause_req_ctrl_tb;
    import pfc_pkg::*;

    localparam int LEVEL_W = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic [LEVEL_W-1:0] fifo_level = '0;
    logic               fifo_empty = 1'b0, desc_unavail = 1'b0, rx_pause_seen = 1'b0;
    logic               tx_pause_req;
    logic [TIMER_W-1:0] tx_pause_timer;
    logic               tx_pause_ack = 1'b0, tx_pause_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pause_req_ctrl #(.LEVEL_W(LEVEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_level(fifo_level), .fifo_empty(fifo_empty),
        .desc_unavail(desc_unavail), .rx_pause_seen(rx_pause_seen),
        .tx_pause_req(tx_pause_req), .tx_pause_timer(tx_pause_timer),
        .tx_pause_ack(tx_pause_ack), .tx_pause_done(tx_pause_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] cw(input int thr, input bit fifo, input bit desc,
                                            input bit anym, input bit xon, input bit xoff,
                                            input bit fc);
        logic [DATA_W-1:0] w;
        w = '0;
        w[THR_W-1:0] = THR_W'(thr);
        w[B_FIFO_EN] = fifo;
        w[B_DESC_EN] = desc;
        w[B_ANYMODE] = anym;
        w[B_CMD_XON] = xon;
        w[B_CMD_XOF] = xoff;
        w[B_FC_EN]   = fc;
        return w;
    endfunction

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic no_req(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, 32'(tx_pause_req), 32'd0);
        end
    endtask

    // transmitter model: wait for the request, check timer, accept, complete
    task automatic serve(input logic [TIMER_W-1:0] exp, input string tag, input bit hold);
        bit seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (tx_pause_req) seen = 1'b1;
        end
        chk({tag, " request raised"}, 32'(seen), 32'd1);
        if (!seen) return;
        chk({tag, " timer"}, 32'(tx_pause_timer), 32'(exp));
        if (hold) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R9 request held before accept", 32'(tx_pause_req), 32'd1);
                chk("R9 timer stable before accept", 32'(tx_pause_timer), 32'(exp));
            end
        end
        tx_pause_ack = 1'b1;
        @(negedge clk);
        tx_pause_ack = 1'b0;
        chk("R9 request dropped after accept", 32'(tx_pause_req), 32'd0);
        @(negedge clk);
        chk("R9 no request before done", 32'(tx_pause_req), 32'd0);
        tx_pause_done = 1'b1;
        @(negedge clk);
        tx_pause_done = 1'b0;
    endtask

    task automatic set_fifo(input int lvl, input bit emp);
        @(negedge clk);
        fifo_level = LEVEL_W'(lvl);
        fifo_empty = emp;
    endtask

    task automatic test_reset();
        logic [DATA_W-1:0] d;
        chk("R1 request low after reset", 32'(tx_pause_req), 32'd0);
        reg_read(ADDR_CTRL, d);
        chk("R1 control reads zero", 32'(d), 32'd0);
        reg_read(ADDR_STAT, d);
        chk("R1 status reads zero", 32'(d), 32'd0);
    endtask

    task automatic test_fifo_triggers();
        reg_write(ADDR_CTRL, cw(0, 1, 0, 1, 0, 0, 0));
        set_fifo(0, 1);
        no_req(6, "R4 empty edge without prior XOFF");
        set_fifo(0, 0);
        set_fifo(500, 0);
        no_req(6, "R2 threshold field zero disables");
        set_fifo(0, 0);
        reg_write(ADDR_CTRL, cw(4, 1, 0, 1, 0, 0, 0));
        set_fifo(127, 0);
        no_req(6, "R2 below threshold");
        set_fifo(128, 0);
        serve(TIMER_XOFF, "R2 near-full XOFF", 1'b0);
        set_fifo(200, 0);
        no_req(10, "R3 no repeat while near full");
        set_fifo(0, 1);
        serve(TIMER_XON, "R4 XON on empty after XOFF", 1'b0);
        no_req(4, "R4 single XON");
    endtask

    task automatic test_and_mode();
        reg_write(ADDR_CTRL, cw(4, 1, 0, 0, 0, 0, 0));
        set_fifo(150, 0);
        no_req(8, "R5 AND mode with one enable discards trigger");
        reg_write(ADDR_CTRL, cw(4, 1, 1, 0, 0, 0, 0));
        @(negedge clk);
        desc_unavail = 1'b1;
        serve(TIMER_XOFF, "R6 descriptor-unavailable XOFF", 1'b0);
        @(negedge clk);
        desc_unavail = 1'b0;
        set_fifo(0, 1);
        serve(TIMER_XON, "R4 XON after descriptor XOFF", 1'b0);
    endtask

    task automatic test_sw_commands();
        logic [DATA_W-1:0] d;
        reg_write(ADDR_CTRL, cw(4, 0, 0, 1, 1, 0, 0));
        serve(TIMER_XON, "R7 forced XON", 1'b0);
        reg_read(ADDR_CTRL, d);
        chk("R7 XON command reads back 0", 32'(d[B_CMD_XON]), 32'd0);
        no_req(4, "R7 single forced XON");
        reg_write(ADDR_CTRL, cw(4, 0, 0, 1, 0, 1, 0));
        reg_read(ADDR_CTRL, d);
        chk("R8 XOFF command set before done", 32'(d[B_CMD_XOF]), 32'd1);
        serve(TIMER_XOFF, "R8 forced XOFF", 1'b0);
        reg_read(ADDR_CTRL, d);
        chk("R8 XOFF command cleared after done", 32'(d[B_CMD_XOF]), 32'd0);
        no_req(4, "R8 no repeat after clear");
    endtask

    task automatic test_priority();
        reg_write(ADDR_CTRL, cw(4, 0, 0, 1, 1, 1, 0));
        serve(TIMER_XOFF, "R10 XOFF offered first", 1'b1);
        serve(TIMER_XON, "R10 XON follows", 1'b0);
    endtask

    task automatic test_status();
        logic [DATA_W-1:0] d;
        reg_write(ADDR_CTRL, cw(4, 0, 0, 1, 0, 0, 0));
        @(negedge clk); rx_pause_seen = 1'b1;
        @(negedge clk); rx_pause_seen = 1'b0;
        reg_read(ADDR_STAT, d);
        chk("R11 event ignored when decode disabled", 32'(d), 32'd0);
        reg_write(ADDR_CTRL, cw(4, 0, 0, 1, 0, 0, 1));
        @(negedge clk); rx_pause_seen = 1'b1;
        @(negedge clk); rx_pause_seen = 1'b0;
        no_req(2, "R11 status does not request");
        reg_read(ADDR_STAT, d);
        chk("R11 status set by event", 32'(d), 32'd1);
        reg_read(ADDR_STAT, d);
        chk("R12 status cleared by read", 32'(d), 32'd0);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = ADDR_STAT; rx_pause_seen = 1'b1;
        #1 chk("R12 read returns value before event", 32'(reg_rdata), 32'd0);
        @(negedge clk);
        reg_rd_en = 1'b0; rx_pause_seen = 1'b0;
        reg_read(ADDR_STAT, d);
        chk("R12 event wins over clearing read", 32'(d), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fifo_triggers();
        test_and_mode();
        test_sw_commands();
        test_priority();
        test_status();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule